// File: doc/BRIEF.md
# Modulus Split Point Finder

This block runs once during key setup. It works out where an n-bit modular datapath should be divided into two independent sub-datapaths, so that the two halves of a residue-based exponentiation can run side by side. The divide is set by the bit length of the smaller prime. That prime arrives zero-extended to the full datapath width.

On a load pulse the prime is captured in a working register, and a separate marker register is set to a single bit at position 0. While the working register's top bit is clear, both registers move one place toward the MSB on every cycle. When the top bit becomes set, movement stops. The marker's position is then the split point, and it is presented as a one-hot vector with a completion flag.

A prime of zero would otherwise shift forever. A step counter stops it after WIDTH-1 shifts and raises an error flag instead.

Top module: `split_point_finder`

The controller has four states:
- `S_IDLE`: waits after reset.
- `S_SHIFT`: walks the two registers.
- `S_DONE`: holds the result.
- `S_ERROR`: marks an all-zero prime.

Its transitions are:
- `load` from any state goes to `S_SHIFT`.
- `S_SHIFT` goes to `S_DONE` when the top bit is set.
- `S_SHIFT` goes to `S_ERROR` when the step limit is reached with the top bit still clear.
- `S_IDLE`, `S_DONE` and `S_ERROR` stay where they are without a load.

## Requirements
- R1: After reset, `done`, `zero_err` and `busy` are low, and `split_onehot` is all zeros.
- R2: A cycle with `load` high captures `q_in` and places the marker at bit 0. `busy` is high after that clock edge.
- R3: The internal marker holds exactly one set bit at all times. `split_onehot` has exactly one set bit whenever `done` is high and is all zeros otherwise.
- R4: In every busy cycle in which the working register's top bit is clear, the working register and the marker each move one position toward the MSB. In no other cycle do they move, except on a load.
- R5: Shifting stops once the working register's top bit is 1. For a nonzero prime of bit length L, `done` rises at the (WIDTH-L+1)-th rising edge after the edge that captured the load.
- R6: When `done` is high, the single set bit of `split_onehot` is at index WIDTH-L.
- R7: Once high, `done` and `split_onehot` stay unchanged until the next load.
- R8: A zero prime never raises `done`. After WIDTH-1 shifts, `zero_err` rises at the WIDTH-th edge after the load edge and stays high until the next load, with `split_onehot` all zeros.
- R9: A load while busy, done or in error restarts the search with the new value and discards the earlier one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture `q_in` and start a search |
| q_in | input | WIDTH | Smaller prime, zero-extended to the datapath width |
| split_onehot | output | WIDTH | One-hot split position, valid while `done` is high |
| done | output | 1 | Search finished with a valid split |
| zero_err | output | 1 | Search aborted because the prime was zero |
| busy | output | 1 | Search in progress |

## Verification
The bench builds the block with WIDTH = 12. At that width every bit length from 1 to 12 can be swept, so both extremes are covered. The full-length prime needs no shift at all. The one-bit prime needs the maximum WIDTH-1 shifts, which is the same step count at which the zero check trips. Each length is applied with a sparse pattern (top bit only) and a dense one (all ones below the top). Zero input, holding after completion, and a reload during a running search are exercised as separate scenarios.

// File: rtl/split_pkg.sv
package split_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_DONE  = 2'd2,
        S_ERROR = 2'd3
    } split_state_t;
endpackage

// File: rtl/split_shift_regs.sv
module split_shift_regs #(
    parameter int WIDTH = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] q_in,
    input  logic             shift_en,
    output logic             q_msb,
    output logic             cnt_last,
    output logic [WIDTH-1:0] mark
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    logic [WIDTH-1:0] q_q;
    logic [WIDTH-1:0] mark_q;
    logic [CW-1:0]    step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q    <= '0;
            mark_q <= WIDTH'(1);
            step_q <= '0;
        end else if (load) begin
            q_q    <= q_in;
            mark_q <= WIDTH'(1);
            step_q <= '0;
        end else if (shift_en) begin
            q_q    <= {q_q[WIDTH-2:0], 1'b0};
            mark_q <= {mark_q[WIDTH-2:0], 1'b0};
            step_q <= step_q + 1'b1;
        end
    end

    assign q_msb    = q_q[WIDTH-1];
    assign cnt_last = (step_q == LAST_STEP);
    assign mark     = mark_q;

    // R3: marker is one-hot at all times
    a_r3_single_marker: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mark_q) == 1);

    // R4: no movement without shift enable or load
    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift_en) |=> ($stable(q_q) && $stable(mark_q)));

    // R4: a shift empties bit 0 of the marker
    a_r4_marker_leaves_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && shift_en) |=> (mark_q[0] == 1'b0));
endmodule

// File: rtl/split_ctrl.sv
module split_ctrl
    import split_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic q_msb,
    input  logic cnt_last,
    output logic shift_en,
    output logic done,
    output logic zero_err,
    output logic busy
);
    split_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = S_SHIFT;
        end else begin
            unique case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_SHIFT: begin
                    if (q_msb)         state_d = S_DONE;
                    else if (cnt_last) state_d = S_ERROR;
                    else               state_d = S_SHIFT;
                end
                S_DONE:  state_d = S_DONE;
                S_ERROR: state_d = S_ERROR;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_comb begin
        shift_en = 1'b0;
        done     = 1'b0;
        zero_err = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_SHIFT: begin
                busy     = 1'b1;
                shift_en = !q_msb && !cnt_last && !load;
            end
            S_DONE:  done     = 1'b1;
            S_ERROR: zero_err = 1'b1;
            default: ;
        endcase
    end

    // R5: top bit set while searching ends the search
    a_r5_stop_on_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SHIFT && q_msb && !load) |=> (state_q == S_DONE));

    // R5: completion implies the working register's top bit is set
    a_r5_done_has_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |-> q_msb);

    // R7: result held until the next load
    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE && !load) |=> (state_q == S_DONE));

    // R8: step limit with clear top bit ends in error
    a_r8_bounded_search: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SHIFT && cnt_last && !q_msb && !load) |=> (state_q == S_ERROR));

    // R9: a load always restarts the search
    a_r9_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q == S_SHIFT));
endmodule

// File: rtl/split_point_finder.sv
module split_point_finder #(
    parameter int WIDTH = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] q_in,
    output logic [WIDTH-1:0] split_onehot,
    output logic             done,
    output logic             zero_err,
    output logic             busy
);
    logic             shift_en;
    logic             q_msb;
    logic             cnt_last;
    logic [WIDTH-1:0] mark;

    split_shift_regs #(.WIDTH(WIDTH)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .q_in     (q_in),
        .shift_en (shift_en),
        .q_msb    (q_msb),
        .cnt_last (cnt_last),
        .mark     (mark)
    );

    split_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .q_msb    (q_msb),
        .cnt_last (cnt_last),
        .shift_en (shift_en),
        .done     (done),
        .zero_err (zero_err),
        .busy     (busy)
    );

    assign split_onehot = done ? mark : '0;

    // R3: valid split is one-hot
    a_r3_split_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(split_onehot) == 1));

    // R8: error and completion never coincide
    a_r8_err_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && zero_err));
endmodule

// File: tb/test_split_point_finder.sv
module test_split_point_finder;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] q_in = '0;
    logic [W-1:0] split_onehot;
    logic         done, zero_err, busy;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    split_point_finder #(.WIDTH(W)) i_split_point_finder (
        .clk(clk), .rst_n(rst_n), .load(load), .q_in(q_in),
        .split_onehot(split_onehot), .done(done), .zero_err(zero_err), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bit_len(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) if (v[i]) n = i + 1;
        return n;
    endfunction

    // drive a load on a negedge; returns one negedge after the capturing edge
    task automatic do_load(input logic [W-1:0] v);
        @(negedge clk);
        load = 1'b1;
        q_in = v;
        @(negedge clk);
        load = 1'b0;
        q_in = '0;
    endtask

    // count edges after the capture edge until done or error
    task automatic wait_result(output int edges);
        edges = 0;
        while (!done && !zero_err && edges < W + 4) begin
            @(negedge clk);
            edges++;
        end
    endtask

    task automatic test_reset();
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(zero_err == 1'b0, "R1", "zero_err after reset", zero_err, 0);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(split_onehot == '0, "R1", "split after reset", split_onehot, 0);
    endtask

    task automatic test_prime(input logic [W-1:0] v);
        int edges;
        int len = bit_len(v);
        logic [W-1:0] exp_split = W'(1) << (W - len);
        do_load(v);
        check(busy == 1'b1, "R2", "busy after load", busy, 1);
        check(split_onehot == '0, "R3", "split gated while busy", split_onehot, 0);
        wait_result(edges);
        check(done == 1'b1 && zero_err == 1'b0, "R5", "done reached", {zero_err, done}, 1);
        check(edges == W - len + 1, "R5", "done latency", edges, W - len + 1);
        check($countones(split_onehot) == 1, "R3", "split one-hot", split_onehot, exp_split);
        check(split_onehot == exp_split, "R6", "split position", split_onehot, exp_split);
    endtask

    task automatic test_hold();
        logic [W-1:0] v = W'(12'h0A5);
        logic [W-1:0] exp_split = W'(1) << (W - bit_len(v));
        int edges;
        do_load(v);
        wait_result(edges);
        repeat (10) @(negedge clk);
        check(done == 1'b1, "R7", "done held", done, 1);
        check(split_onehot == exp_split, "R7", "split held", split_onehot, exp_split);
        check(busy == 1'b0, "R4", "no further activity", busy, 0);
    endtask

    task automatic test_zero();
        int edges;
        do_load('0);
        wait_result(edges);
        check(zero_err == 1'b1, "R8", "zero flagged", zero_err, 1);
        check(done == 1'b0, "R8", "no done on zero", done, 0);
        check(edges == W, "R8", "zero abort latency", edges, W);
        repeat (6) @(negedge clk);
        check(zero_err == 1'b1 && done == 1'b0, "R8", "error held", {zero_err, done}, 2);
        check(split_onehot == '0, "R8", "split zero in error", split_onehot, 0);
    endtask

    task automatic test_restart();
        int edges;
        logic [W-1:0] second = W'(1) << (W - 2);
        do_load(W'(2));
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R9", "first search still busy", busy, 1);
        do_load(second);
        wait_result(edges);
        check(done == 1'b1, "R9", "restart done", done, 1);
        check(edges == 2, "R9", "restart latency", edges, 2);
        check(split_onehot == W'(2), "R9", "restart split", split_onehot, 2);
        // reload from the error state
        do_load('0);
        wait_result(edges);
        do_load(W'(1) << (W - 1));
        wait_result(edges);
        check(done == 1'b1 && edges == 1, "R9", "reload after error", edges, 1);
        check(split_onehot == W'(1), "R9", "split after error reload", split_onehot, 1);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        for (int len = 1; len <= W; len++) begin
            test_prime(W'(1) << (len - 1));
            test_prime((W'(1) << len) - W'(1));
        end
        test_hold();
        test_zero();
        test_restart();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule